// File: doc/BRIEF.md
# Two-Way Processor Message Mailbox

This block moves 32-bit messages between a host processor and a second processor. The host sees a small word-wide register window. It queues outgoing messages by writing one register and collects incoming messages by reading another. A status register tells it whether the outgoing queue can take another word and whether anything is waiting to be read.

The second processor connects through two valid/ready ports. One port drains outgoing messages and the other fills the incoming queue. Every message word carries a 4-bit logical channel number in bits [3:0] and a 28-bit payload in bits [31:4]. On the far side the block presents the two fields separately and joins them again on the way in. Each direction has its own small first-in first-out queue.

A write that arrives while the outgoing queue is full is discarded and leaves a sticky flag in the configuration register. Software clears that flag explicitly.

Top module: `mbox_regif`

## Requirements
- R1: After reset the status register (offset 0x18) reads 0x4000_0000, the configuration register (offset 0x1C) reads 0, `tx_valid` is 0 and `rx_ready` is 1.
- R2: Each write to offset 0x20 with the outgoing queue not full appends the word to the outgoing queue. The far side receives the words on `tx_chan`/`tx_payload` in write order, one per cycle with `tx_valid` and `tx_ready` both high. While `tx_ready` is low, the presented word is held.
- R3: Status bit 31 reads 1 exactly when the outgoing queue holds 4 words (DEPTH) that have not been drained.
- R4: A write to offset 0x20 while the outgoing queue is full is discarded and leaves the queued words unchanged. It also sets configuration bit 0 (overflow).
- R5: The overflow bit stays set until a write to offset 0x1C with data bit 0 equal to 1. A write there with bit 0 equal to 0 leaves it set.
- R6: The far side pushes a word with `rx_valid` and `rx_ready` both high. `rx_ready` is 0 while the incoming queue holds 4 words. Reads of offset 0x00 return the incoming words in arrival order and remove each one as it is read.
- R7: Status bit 30 reads 1 exactly when the incoming queue is empty.
- R8: A read of offset 0x00 while the incoming queue is empty returns 0 and does not disturb the queue. The next word pushed is the next word read.
- R9: Offsets 0x04 to 0x14 and the write register read as 0, and writes to them, to offset 0x00 and to the status register have no effect. Status bits [29:0] read as 0.
- R10: A message word is split as channel = bits [3:0] and payload = bits [31:4]. An incoming pair `rx_chan`/`rx_payload` reads back as {payload, channel}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W (6) | Byte offset of the register access |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on offset 0x00) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the addressed register |
| tx_valid | output | 1 | Outgoing word available |
| tx_ready | input | 1 | Far side takes the outgoing word |
| tx_chan | output | 4 | Channel field of the outgoing word |
| tx_payload | output | 28 | Payload field of the outgoing word |
| rx_valid | input | 1 | Far side offers an incoming word |
| rx_ready | output | 1 | Incoming queue has room |
| rx_chan | input | 4 | Channel field of the incoming word |
| rx_payload | input | 28 | Payload field of the incoming word |

## Verification
The hardest situation to reach from the ports is a dropped write. It needs the outgoing queue completely full while the far side holds `tx_ready` low. The bench keeps the drain port idle for four writes and confirms the full flag through the status register. It then issues a fifth write and drains all four words, which shows both that the extra word never entered the queue and that the sticky flag was raised. The empty-read case is handled the same way: the bench reads an empty incoming queue first and then pushes a single word, so any pointer movement caused by the empty read shows up as a wrong or missing word.

// File: rtl/mbox_regif_pkg.sv
package mbox_regif_pkg;

    localparam int WORD_W = 32;
    localparam int CHAN_W = 4;
    localparam int PAY_W  = WORD_W - CHAN_W;

    // Register offsets (byte addresses)
    localparam logic [7:0] OFF_POP    = 8'h00;
    localparam logic [7:0] OFF_STATUS = 8'h18;
    localparam logic [7:0] OFF_CFG    = 8'h1C;
    localparam logic [7:0] OFF_PUSH   = 8'h20;

    // Bit positions in status and configuration
    localparam int BIT_TX_FULL  = 31;
    localparam int BIT_RX_EMPTY = 30;
    localparam int BIT_OVF      = 0;

    localparam logic [WORD_W-1:0] CHAN_MASK = WORD_W'((1 << CHAN_W) - 1);

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_POP,
        SEL_STATUS,
        SEL_CFG,
        SEL_PUSH
    } reg_sel_e;

    // Join a channel number and a data word: channel under the mask, data above it
    function automatic logic [WORD_W-1:0] msg_pack(input logic [CHAN_W-1:0] chan,
                                                   input logic [WORD_W-1:0] data);
        return (data & ~CHAN_MASK) | (WORD_W'(chan) & CHAN_MASK);
    endfunction

    function automatic logic [CHAN_W-1:0] msg_chan(input logic [WORD_W-1:0] word);
        return CHAN_W'(word & CHAN_MASK);
    endfunction

    function automatic logic [PAY_W-1:0] msg_payload(input logic [WORD_W-1:0] word);
        return PAY_W'((word & ~CHAN_MASK) >> CHAN_W);
    endfunction

endpackage

// File: rtl/mbox_regif_fifo.sv
module mbox_regif_fifo
    import mbox_regif_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int WIDTH = WORD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign full    = (count == CNT_FULL);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = store[rd_ptr];

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (do_push && wr_ptr == PTR_W'(i)) store[i] <= push_data;
            end
        end
    endgenerate

endmodule

// File: rtl/mbox_regif_regs.sv
module mbox_regif_regs
    import mbox_regif_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              tx_full,
    input  logic              rx_empty,
    input  logic [WORD_W-1:0] rx_head,
    output logic              tx_push,
    output logic [WORD_W-1:0] tx_word,
    output logic              rx_pop,
    output logic              ovf
);
    localparam logic [ADDR_W-1:0] A_POP    = ADDR_W'(OFF_POP);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
    localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'(OFF_CFG);
    localparam logic [ADDR_W-1:0] A_PUSH   = ADDR_W'(OFF_PUSH);

    reg_sel_e          sel;
    logic              drop;
    logic              ovf_clr;
    logic [WORD_W-1:0] status_word;

    always_comb begin
        if (reg_addr == A_POP)         sel = SEL_POP;
        else if (reg_addr == A_STATUS) sel = SEL_STATUS;
        else if (reg_addr == A_CFG)    sel = SEL_CFG;
        else if (reg_addr == A_PUSH)   sel = SEL_PUSH;
        else                           sel = SEL_NONE;
    end

    assign tx_push = reg_wr && (sel == SEL_PUSH) && !tx_full;
    assign drop    = reg_wr && (sel == SEL_PUSH) && tx_full;
    assign ovf_clr = reg_wr && (sel == SEL_CFG) && reg_wdata[BIT_OVF];
    assign rx_pop  = reg_rd && (sel == SEL_POP) && !rx_empty;
    assign tx_word = msg_pack(msg_chan(reg_wdata), reg_wdata);

    always_ff @(posedge clk) begin
        if (rst)          ovf <= 1'b0;
        else if (drop)    ovf <= 1'b1;
        else if (ovf_clr) ovf <= 1'b0;
    end

    always_comb begin
        status_word = '0;
        status_word[BIT_TX_FULL]  = tx_full;
        status_word[BIT_RX_EMPTY] = rx_empty;
    end

    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_POP:    reg_rdata = rx_empty ? '0 : rx_head;
            SEL_STATUS: reg_rdata = status_word;
            SEL_CFG:    reg_rdata[BIT_OVF] = ovf;
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mbox_regif.sv
module mbox_regif
    import mbox_regif_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [CHAN_W-1:0] tx_chan,
    output logic [PAY_W-1:0]  tx_payload,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [CHAN_W-1:0] rx_chan,
    input  logic [PAY_W-1:0]  rx_payload
);
    logic              tx_full_w, tx_empty_w, tx_push_w;
    logic              rx_full_w, rx_empty_w, rx_pop_w;
    logic              ovf_w;
    logic [WORD_W-1:0] tx_word_w, tx_head_w, rx_head_w, rx_word_w;

    mbox_regif_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .tx_full   (tx_full_w),
        .rx_empty  (rx_empty_w),
        .rx_head   (rx_head_w),
        .tx_push   (tx_push_w),
        .tx_word   (tx_word_w),
        .rx_pop    (rx_pop_w),
        .ovf       (ovf_w)
    );

    mbox_regif_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_tx_q (
        .clk       (clk),
        .rst       (rst),
        .push      (tx_push_w),
        .push_data (tx_word_w),
        .pop       (tx_valid && tx_ready),
        .head      (tx_head_w),
        .full      (tx_full_w),
        .empty     (tx_empty_w)
    );

    assign rx_word_w = msg_pack(rx_chan, {rx_payload, {CHAN_W{1'b0}}});

    mbox_regif_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_rx_q (
        .clk       (clk),
        .rst       (rst),
        .push      (rx_valid && rx_ready),
        .push_data (rx_word_w),
        .pop       (rx_pop_w),
        .head      (rx_head_w),
        .full      (rx_full_w),
        .empty     (rx_empty_w)
    );

    assign tx_valid   = !tx_empty_w;
    assign rx_ready   = !rx_full_w;
    assign tx_chan    = msg_chan(tx_head_w);
    assign tx_payload = msg_payload(tx_head_w);

endmodule

// File: rtl/mbox_regif_chk.sv
module mbox_regif_chk
    import mbox_regif_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic              wdata0,
    input logic [WORD_W-1:0] reg_rdata,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [CHAN_W-1:0] tx_chan,
    input logic [PAY_W-1:0]  tx_payload,
    input logic              rx_ready,
    input logic              tx_full,
    input logic              rx_empty,
    input logic              ovf
);
    localparam logic [ADDR_W-1:0] A_POP    = ADDR_W'(OFF_POP);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
    localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'(OFF_CFG);
    localparam logic [ADDR_W-1:0] A_PUSH   = ADDR_W'(OFF_PUSH);
    localparam logic [ADDR_W-1:0] A_RSV_LO = ADDR_W'(8'h04);
    localparam logic [ADDR_W-1:0] A_RSV_HI = ADDR_W'(8'h14);

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_chan) && $stable(tx_payload)); // R2

    AST_FULL_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
        tx_full |-> tx_valid); // R3

    AST_DROP_SETS_OVF: assert property (@(posedge clk) disable iff (rst)
        reg_wr && reg_addr == A_PUSH && tx_full |=> ovf); // R4

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf && !(reg_wr && reg_addr == A_CFG && wdata0) |=> ovf); // R5

    AST_RX_BACKPRESSURE: assert property (@(posedge clk) disable iff (rst)
        !rx_ready |-> !rx_empty); // R6

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        reg_rd && reg_addr == A_POP && rx_empty |-> reg_rdata == '0); // R8

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        reg_rd && reg_addr >= A_RSV_LO && reg_addr <= A_RSV_HI |-> reg_rdata == '0); // R9

    AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        reg_rd && reg_addr == A_STATUS |-> reg_rdata[BIT_RX_EMPTY-1:0] == '0); // R9

endmodule

bind mbox_regif mbox_regif_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .wdata0     (reg_wdata[0]),
    .reg_rdata  (reg_rdata),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_chan    (tx_chan),
    .tx_payload (tx_payload),
    .rx_ready   (rx_ready),
    .tx_full    (tx_full_w),
    .rx_empty   (rx_empty_w),
    .ovf        (ovf_w)
);

// File: tb/mbox_regif_bench.sv
module mbox_regif_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [3:0]  tx_chan;
    logic [27:0] tx_payload;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [3:0]  rx_chan = '0;
    logic [27:0] rx_payload = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    mbox_regif u_mbox_regif (
        .clk(clk), .rst(rst),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_chan(tx_chan), .tx_payload(tx_payload),
        .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_chan(rx_chan), .rx_payload(rx_payload)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // Drain one word on the far side; returns {payload, chan} and valid
    task automatic far_pop(output logic v, output logic [31:0] w);
        @(negedge clk);
        tx_ready = 1'b1;
        #1 v = tx_valid; w = {tx_payload, tx_chan};
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    task automatic far_push(input logic [3:0] c, input logic [27:0] p, output logic rdy);
        @(negedge clk);
        rx_valid = 1'b1; rx_chan = c; rx_payload = p;
        #1 rdy = rx_ready;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        reg_read(6'h18, d); chk("R1 status after reset", d, 32'h4000_0000);
        reg_read(6'h1C, d); chk("R1 config after reset", d, 32'h0);
        #1;
        chk("R1 tx_valid after reset", {31'b0, tx_valid}, 32'h0);
        chk("R1 rx_ready after reset", {31'b0, rx_ready}, 32'h1);
    endtask

    task automatic t_order();
        logic [31:0] w [3];
        logic [31:0] got;
        logic v;
        w[0] = 32'hABCD_E123; w[1] = 32'h1234_567F; w[2] = 32'h0000_0010;
        for (int i = 0; i < 3; i++) reg_write(6'h20, w[i]);
        // hold check: tx_ready low keeps first word presented
        @(negedge clk); #1;
        chk("R2 held word while not ready", {tx_payload, tx_chan}, w[0]);
        for (int i = 0; i < 3; i++) begin
            far_pop(v, got);
            chk("R2 tx_valid in order", {31'b0, v}, 32'h1);
            chk("R10 tx chan/payload split", got, w[i]);
        end
        @(negedge clk); #1;
        chk("R2 tx empty after drain", {31'b0, tx_valid}, 32'h0);
    endtask

    task automatic t_full_overflow();
        logic [31:0] d, got;
        logic v;
        for (int i = 0; i < 3; i++) begin
            reg_write(6'h20, 32'h5000_0000 + 32'(i * 17));
            reg_read(6'h18, d);
            chk("R3 not full below depth", d, 32'h4000_0000);
        end
        reg_write(6'h20, 32'h5000_0033);
        reg_read(6'h18, d); chk("R3 full flag at depth", d, 32'hC000_0000);
        reg_read(6'h1C, d); chk("R4 no overflow before drop", d, 32'h0);
        reg_write(6'h20, 32'hDEAD_BEEF);
        reg_read(6'h1C, d); chk("R4 overflow set on drop", d, 32'h1);
        for (int i = 0; i < 3; i++) begin
            far_pop(v, got);
            chk("R4 queued word kept", got, 32'h5000_0000 + 32'(i * 17));
        end
        far_pop(v, got); chk("R4 last queued word", got, 32'h5000_0033);
        @(negedge clk); #1;
        chk("R4 dropped word absent", {31'b0, tx_valid}, 32'h0);
    endtask

    task automatic t_ovf_clear();
        logic [31:0] d;
        reg_write(6'h1C, 32'hFFFF_FFFE);
        reg_read(6'h1C, d); chk("R5 write 0 keeps overflow", d, 32'h1);
        reg_write(6'h1C, 32'h0000_0001);
        reg_read(6'h1C, d); chk("R5 write 1 clears overflow", d, 32'h0);
    endtask

    task automatic t_rx_path();
        logic [31:0] d;
        logic rdy;
        reg_read(6'h18, d); chk("R7 empty flag before push", d, 32'h4000_0000);
        for (int i = 0; i < 4; i++) begin
            far_push(4'(i + 9), 28'hA00_0000 + 28'(i), rdy);
            chk("R6 rx_ready while room", {31'b0, rdy}, 32'h1);
        end
        reg_read(6'h18, d); chk("R7 empty flag clear", d, 32'h0);
        far_push(4'h1, 28'hFFF_FFFF, rdy);
        chk("R6 rx_ready low at depth", {31'b0, rdy}, 32'h0);
        for (int i = 0; i < 4; i++) begin
            reg_read(6'h00, d);
            chk("R10 rx word packed in order", d, {28'hA00_0000 + 28'(i), 4'(i + 9)});
        end
        reg_read(6'h18, d); chk("R7 empty flag after reads", d, 32'h4000_0000);
    endtask

    task automatic t_empty_read();
        logic [31:0] d;
        logic rdy;
        reg_read(6'h00, d); chk("R8 empty read returns zero", d, 32'h0);
        reg_read(6'h00, d); chk("R8 second empty read zero", d, 32'h0);
        far_push(4'h6, 28'h0BE_EF01, rdy);
        reg_read(6'h00, d); chk("R8 next push is next read", d, 32'h0BEE_F016);
        reg_read(6'h18, d); chk("R8 queue empty again", d, 32'h4000_0000);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        for (int a = 4; a <= 20; a += 4) begin
            reg_write(6'(a), 32'hFFFF_FFFF);
            reg_read(6'(a), d); chk("R9 reserved reads zero", d, 32'h0);
        end
        reg_write(6'h18, 32'hFFFF_FFFF);
        reg_write(6'h00, 32'hFFFF_FFFF);
        reg_read(6'h18, d); chk("R9 status unchanged by writes", d, 32'h4000_0000);
        reg_read(6'h20, d); chk("R9 push register reads zero", d, 32'h0);
        reg_read(6'h1C, d); chk("R9 config untouched", d, 32'h0);
        #1;
        chk("R9 no push from stray writes", {31'b0, tx_valid}, 32'h0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_order();
        t_full_overflow();
        t_ovf_clear();
        t_rx_path();
        t_empty_read();
        t_reserved();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule